// File: doc/BRIEF.md
# UART Interrupt Pending and Mask Unit

This unit collects the four interrupt causes of a serial port: receive data waiting, receive error, transmitter ready for more data, and a change on the clear-to-send modem line. Each cause is captured in a sticky pending bit. Software acknowledges a cause by writing a one to its bit. A mask register chooses which pending bits may drive the single level-sensitive, active-high interrupt line. A third register shows the live state of the causes before they are latched.

The transmit cause is a condition, not an event. It holds for as long as the transmit FIFO level is below a fixed threshold. Acknowledging it while the FIFO stays low re-latches it on the next clock. Software therefore keeps the transmit cause masked while it has nothing to send, and unmasks it only while a transfer is in progress. The receive cause behaves the same way while data is waiting or a receive timeout is flagged.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A cycle with `rst` high leaves pending at 0 and mask at 4'hF, so `irq` is low after reset.
- R2: Every register view uses this bit order: bit 0 receive, bit 1 error, bit 2 transmit ready, bit 3 CTS change. Register address 1 reads the live (unlatched) source state, zero-extended.
- R3: A source that is active in a cycle sets its pending bit at the next clock edge. The bit then stays set until software clears it, even after the source goes away. Address 0 reads the pending bits.
- R4: A write to address 0 clears every pending bit whose data bit is 1 and leaves every bit whose data bit is 0. Several bits can be cleared in one write.
- R5: When a source is active in the same cycle as a clear of its bit, the bit stays set.
- R6: Address 2 is the read/write mask register. A mask bit of 1 keeps that pending bit off `irq`, and writing 4'hF masks every source.
- R7: `irq` is high exactly when some pending bit has its mask bit at 0. Bits latch while masked, so clearing the mask of a pending bit raises `irq` right after the write edge.
- R8: The transmit-ready source is active while `tx_level` < `TX_THRESH`. While that condition persists, it re-latches on the clock after a clear.
- R9: The receive source is active when `rx_avail` or `rx_timeout` is high. The error source is active when any bit of `err_flags` is high.
- R10: The CTS source is active in a cycle when `cts_in` differs from its value on the previous clock. A level already present during reset gives no event.
- R11: Writes to address 1 and address 3 change no state. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pending, 1 live status, 2 mask, 3 unused |
| reg_wdata | input | DATA_W | Write data; bits 3:0 are used |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| rx_avail | input | 1 | Received data waiting |
| rx_timeout | input | 1 | Receive timeout flagged |
| err_flags | input | ERR_W | Receive error flags (any bit active) |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| cts_in | input | 1 | Clear-to-send line level |
| irq | output | 1 | Level interrupt, active high |

## Verification
The assertions assume that the source inputs change only between clock edges and are stable around each rising edge. They also assume that `reg_wr` is a single-cycle strobe whose address and data are valid in that cycle. The bench drives every input on the falling edge and holds it for a whole period. This keeps each source condition and each write inside one well-defined cycle, including the cycles where a set and a clear coincide.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC    = 4;
    localparam int IDX_RX  = 0;
    localparam int IDX_ERR = 1;
    localparam int IDX_TXR = 2;
    localparam int IDX_CTS = 3;

    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_LIVE = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic cts;
        logic txr;
        logic err;
        logic rx;
    } src_vec_t;

    typedef struct packed {
        logic             wr;
        reg_sel_e         sel;
        logic [NSRC-1:0]  bits;
    } reg_cmd_t;

    localparam logic [NSRC-1:0] MASK_RESET = {NSRC{1'b1}};

    function automatic logic next_pending(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

    function automatic logic any_unmasked(input logic [NSRC-1:0] pend, input logic [NSRC-1:0] mask);
        return |(pend & ~mask);
    endfunction

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_irq_pkg::*;
#(
    parameter int LVL_W     = 5,
    parameter int ERR_W     = 4,
    parameter int TX_THRESH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_avail,
    input  logic             rx_timeout,
    input  logic [ERR_W-1:0] err_flags,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             cts_in,
    output src_vec_t         live
);
    localparam logic [LVL_W-1:0] THR = LVL_W'(TX_THRESH);

    logic cts_q;

    // Track the line during reset too, so a static level is no event.
    always_ff @(posedge clk) begin
        cts_q <= cts_in;
    end

    always_comb begin
        live     = '0;
        live.rx  = rx_avail | rx_timeout;
        live.err = |err_flags;
        live.txr = (tx_level < THR);
        live.cts = (cts_in ^ cts_q) & ~rst;
    end

endmodule

// File: rtl/uart_irq_pend.sv
module uart_irq_pend
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] pend
);
    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) pend[g] <= 1'b0;
            else     pend[g] <= next_pending(pend[g], set_vec[g], clr_vec[g]);
        end
    end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_cmd_t          cmd,
    input  logic [NSRC-1:0]   pend,
    input  logic [NSRC-1:0]   live,
    output logic [NSRC-1:0]   mask,
    output logic [NSRC-1:0]   clr_vec,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)                                 mask <= MASK_RESET;
        else if (cmd.wr && cmd.sel == SEL_MASK)  mask <= cmd.bits;
    end

    assign clr_vec = (cmd.wr && cmd.sel == SEL_PEND) ? cmd.bits : '0;

    always_comb begin
        rdata = '0;
        unique case (cmd.sel)
            SEL_PEND: rdata[NSRC-1:0] = pend;
            SEL_LIVE: rdata[NSRC-1:0] = live;
            SEL_MASK: rdata[NSRC-1:0] = mask;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LVL_W     = 5,
    parameter int ERR_W     = 4,
    parameter int TX_THRESH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_avail,
    input  logic              rx_timeout,
    input  logic [ERR_W-1:0]  err_flags,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              cts_in,
    output logic              irq
);
    src_vec_t        live_s;
    logic [NSRC-1:0] raw_vec;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] clr_vec;
    reg_cmd_t        cmd;

    assign cmd.wr   = reg_wr;
    assign cmd.sel  = reg_sel_e'(reg_addr);
    assign cmd.bits = reg_wdata[NSRC-1:0];
    assign raw_vec  = live_s;

    uart_irq_src #(.LVL_W(LVL_W), .ERR_W(ERR_W), .TX_THRESH(TX_THRESH)) u_src (
        .clk(clk), .rst(rst), .rx_avail(rx_avail), .rx_timeout(rx_timeout),
        .err_flags(err_flags), .tx_level(tx_level), .cts_in(cts_in), .live(live_s)
    );

    uart_irq_pend u_pend (
        .clk(clk), .rst(rst), .set_vec(raw_vec), .clr_vec(clr_vec), .pend(pend_q)
    );

    uart_irq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .cmd(cmd), .pend(pend_q), .live(raw_vec),
        .mask(mask_q), .clr_vec(clr_vec), .rdata(reg_rdata)
    );

    assign irq = any_unmasked(pend_q, mask_q);

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
    parameter int DATA_W    = 32,
    parameter int LVL_W     = 5,
    parameter int TX_THRESH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [LVL_W-1:0]  tx_level,
    input logic [3:0]        raw,
    input logic [3:0]        pend,
    input logic [3:0]        mask,
    input logic              irq
);
    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (raw != 4'd0) |=> ((pend & $past(raw)) == $past(raw)));                      // R3

    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0) |=> ((pend & $past(reg_wdata[3:0] & ~raw)) == 4'd0)); // R4

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && (reg_wdata[3:0] & raw) != 4'd0)
        |=> ((pend & $past(reg_wdata[3:0] & raw)) == $past(reg_wdata[3:0] & raw))); // R5

    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask == 4'hF) |-> !irq);                                                    // R6

    AST_TX_RELATCH: assert property (@(posedge clk) disable iff (rst)
        (tx_level < LVL_W'(TX_THRESH)) |=> pend[2]);                                 // R8

    AST_RO_KEEPS_MASK: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != 2'd2) |=> (mask == $past(mask)));                     // R11
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W), .TX_THRESH(TX_THRESH)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .tx_level(tx_level), .raw(raw_vec), .pend(pend_q), .mask(mask_q), .irq(irq)
);

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
    localparam int PERIOD = 10;
    localparam int DW = 32;
    localparam int LW = 5;
    localparam int EW = 4;
    localparam int THR = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic rx_avail = 1'b0, rx_timeout = 1'b0, cts_in = 1'b0;
    logic [EW-1:0] err_flags = '0;
    logic [LW-1:0] tx_level = LW'(10);
    logic irq;

    always #(PERIOD/2) clk = ~clk;

    uart_irq_ctrl #(.DATA_W(DW), .LVL_W(LW), .ERR_W(EW), .TX_THRESH(THR)) u_uart_irq_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_avail(rx_avail), .rx_timeout(rx_timeout),
        .err_flags(err_flags), .tx_level(tx_level), .cts_in(cts_in), .irq(irq)
    );

    int n_cmp = 0, n_bad = 0;
    int m_pend = 0, m_mask = 15, m_cts = 0;
    bit m_valid = 0;

    function automatic int live_now();
        int v = 0;
        if (rx_avail || rx_timeout) v |= 1;
        if (err_flags != 0)         v |= 2;
        if (int'(tx_level) < THR)   v |= 4;
        if (!rst && int'(cts_in) != m_cts) v |= 8;
        return v;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        int exp_rd, exp_irq;
        #1;
        if (m_valid) begin
            case (reg_addr)
                2'd0: exp_rd = m_pend;
                2'd1: exp_rd = live_now();
                2'd2: exp_rd = m_mask;
                default: exp_rd = 0;
            endcase
            exp_irq = ((m_pend & ~m_mask & 15) != 0) ? 1 : 0;
            check(tag, "irq", int'(irq), exp_irq);
            check(tag, "rdata", int'(reg_rdata), exp_rd);
        end
        @(posedge clk);
        if (rst) begin
            m_pend = 0; m_mask = 15;
        end else begin
            int clr = (reg_wr && reg_addr == 2'd0) ? int'(reg_wdata[3:0]) : 0;
            m_pend = (m_pend & ~clr & 15) | live_now();
            if (reg_wr && reg_addr == 2'd2) m_mask = int'(reg_wdata[3:0]);
        end
        m_cts = int'(cts_in);
        m_valid = 1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr(input int a, input int d, input string tag);
        reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = DW'(d);
        step(tag);
    endtask

    task automatic rd(input int a, input string tag);
        reg_addr = 2'(a);
        step(tag);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        cts_in = 1'b1;                       // level present during reset: no event (R10)
        step("R1"); step("R1");
        rst = 1'b0;
        rd(0, "R1"); rd(2, "R1"); rd(1, "R10");
        // receive source, live and latched (R9, R2)
        rx_avail = 1'b1; rd(1, "R9"); rx_avail = 1'b0; rd(0, "R9");
        rx_timeout = 1'b1; rd(1, "R9"); rx_timeout = 1'b0; rd(0, "R3");
        // error and CTS sources (R2, R10)
        err_flags = 4'b0100; rd(1, "R2"); err_flags = '0; rd(0, "R2");
        cts_in = 1'b0; rd(1, "R10"); rd(0, "R10"); rd(1, "R10");
        // multi-bit clear (R4)
        wr(0, 4'b0011, "R4"); rd(0, "R4");
        wr(0, 4'b1100, "R4"); rd(0, "R4");
        // set beats clear (R5)
        rx_avail = 1'b1; wr(0, 4'b0001, "R5"); rx_avail = 1'b0; rd(0, "R5");
        // mask behaviour (R6, R7)
        wr(2, 4'b1110, "R7"); rd(2, "R7");
        wr(2, 4'hF, "R6"); rd(2, "R6");
        err_flags = 4'b0001; rd(0, "R7"); err_flags = '0; rd(0, "R7");
        wr(2, 4'b1101, "R7"); rd(0, "R7");
        wr(0, 4'hF, "R4"); rd(0, "R4");
        // transmit ready re-latch (R8)
        tx_level = LW'(THR); rd(1, "R8");
        tx_level = LW'(THR - 1); rd(1, "R8");
        wr(0, 4'b0100, "R8"); rd(0, "R8");
        wr(2, 4'b1011, "R8"); rd(0, "R8");
        tx_level = LW'(THR); wr(0, 4'b0100, "R8"); rd(0, "R8");
        // writes to read-only and unused addresses (R11)
        err_flags = 4'b1000; rd(0, "R11"); err_flags = '0;
        wr(1, 4'hF, "R11"); rd(0, "R11"); rd(2, "R11");
        wr(3, 4'hF, "R11"); rd(3, "R11"); rd(0, "R11"); rd(2, "R11");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            rx_avail   = ($urandom_range(0, 7) == 0);
            rx_timeout = ($urandom_range(0, 15) == 0);
            err_flags  = ($urandom_range(0, 9) == 0) ? EW'($urandom_range(1, 15)) : '0;
            tx_level   = LW'($urandom_range(0, 12));
            if ($urandom_range(0, 5) == 0) cts_in = ~cts_in;
            reg_addr   = 2'($urandom_range(0, 3));
            reg_wdata  = DW'($urandom);
            reg_wr     = ($urandom_range(0, 2) == 0);
            step("R7");
        end
        rst = 1'b1; step("R1"); rst = 1'b0; rd(0, "R1"); rd(2, "R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule